// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage. For each of the two source operands of the instruction being decoded, it picks where the value comes from. The choices are the register file, a held copy of the most recent execution result, or a held copy of the most recent memory load. It keeps two small trackers. The first notes the destination of the last execution-path writer. The second notes the destination of the last load, together with a flag that stays set until the load data has come back. When neither tracker can vouch for a value, the operand takes the locking path: if the lock scoreboard marks the register busy, decode waits.

Decoded instructions arrive as a valid/ready stream. The upstream side presents `dec_valid` with a stable payload. An instruction is accepted on a rising edge where `dec_valid` and `dec_ready` are both high, and the payload must not change until then. `dec_ready` depends only on the payload and the tracker state, so it may be low while `dec_valid` is low. Trackers change only on an accepted instruction or on a result strobe. Operand selects and data are combinational from the presented payload.

Two ordering rules apply:
- If a strobe and a new producer of the same kind share an edge, the strobe's data is captured and the pending flag is set for the new producer.
- Result strobes must arrive in the order their producers were accepted.

Top module: `opnd_bypass`

## Requirements
- R1: After reset neither tracker is valid. Every used operand selects the register file (select code 0) and waits only if its register is locked.
- R2: When an accepted instruction writes its destination through the execution path, unconditionally, the next accepted instruction that reads that register gets select code 1. It receives the last execution-strobe data and ignores the lock.
- R3: The last-result match lasts for exactly one following accepted instruction. The one after that reads the register through the normal path.
- R4: After an unconditional load is accepted, every later reader of its destination gets select code 2 and the captured load data, until the tracking is invalidated.
- R5: While load data is still pending, a reader that matches the load destination is not ready and `stall` is high. It becomes ready in the cycle after the load strobe.
- R6: A conditionally executed producer (either kind) sets up no bypass. A conditional load also drops any existing load tracking. Readers then use select code 0 and wait on the lock.
- R7: An accepted execution-path writer whose destination equals the tracked load destination invalidates the load tracking.
- R8: A used operand with no bypass and a locked register drives `stall` high and `dec_ready` low. An unused operand takes select code 0 and never waits, whatever its lock bit says.
- R9: If both trackers could supply a register, the more recent producer wins. That is the last execution result (code 1).
- R10: While the last execution result is still pending, a matching reader is not ready and `stall` is high. It becomes ready in the cycle after the execution strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Decode can accept the presented instruction |
| dec_use_a | input | 1 | Operand A is read |
| dec_src_a | input | RW | Operand A register number |
| dec_use_b | input | 1 | Operand B is read |
| dec_src_b | input | RW | Operand B register number |
| dec_dst | input | RW | Destination register number |
| dec_exec_wr | input | 1 | Instruction writes dst through the execution path |
| dec_load | input | 1 | Instruction writes dst through a memory load |
| dec_cond | input | 1 | Instruction is conditionally executed |
| exe_res_valid | input | 1 | Execution result strobe |
| exe_res_data | input | DW | Execution result value |
| ld_rsp_valid | input | 1 | Load data strobe |
| ld_rsp_data | input | DW | Load data value |
| reg_lock | input | NREGS | Lock scoreboard, one bit per register |
| rf_data_a | input | DW | Register file read data for operand A |
| rf_data_b | input | DW | Register file read data for operand B |
| sel_a | output | 2 | Operand A source: 0 file, 1 last result, 2 last load |
| sel_b | output | 2 | Operand B source, same coding |
| opnd_a | output | DW | Operand A value |
| opnd_b | output | DW | Operand B value |
| stall | output | 1 | Presented instruction must wait |

## Verification
Selects, operand data, `dec_ready` and `stall` are combinational. They are due in the same cycle as the payload and are sampled one time unit after the payload changes on the falling edge. A tracker change caused by an accepted instruction or a strobe shows up from the next rising edge on. The reference model therefore updates its trackers right after each rising edge and predicts the following half cycle from that state. Pending cases (R5, R10) hold one reader across the strobe edge and expect a wait before the edge and a bypass select after it.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_LAST = 2'd1,
    SRC_LOAD = 2'd2
  } opsrc_e;
endpackage

// File: rtl/opbyp_last_result.sv
module opbyp_last_result #(
  parameter int RW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr_exec,
  input  logic          cond,
  input  logic [RW-1:0] dst,
  input  logic          wb_valid,
  input  logic [DW-1:0] wb_data,
  output logic          trk_valid,
  output logic [RW-1:0] trk_reg,
  output logic          trk_pend,
  output logic [DW-1:0] trk_data
);
  logic producer;
  assign producer = acc && wr_exec && !cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_reg   <= '0;
      trk_pend  <= 1'b0;
      trk_data  <= '0;
    end else begin
      if (acc) trk_valid <= producer;
      if (producer) trk_reg <= dst;
      if (producer) trk_pend <= 1'b1;
      else if (wb_valid) trk_pend <= 1'b0;
      if (wb_valid) trk_data <= wb_data;
    end
  end

  assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_exec) |=> !trk_valid);
  assert_cond_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cond) |=> !trk_valid);
  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !producer) |=> !trk_pend);
endmodule

// File: rtl/opbyp_last_load.sv
module opbyp_last_load #(
  parameter int RW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          is_load,
  input  logic          wr_exec,
  input  logic          cond,
  input  logic [RW-1:0] dst,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          trk_valid,
  output logic [RW-1:0] trk_reg,
  output logic          trk_pend,
  output logic [DW-1:0] trk_data
);
  logic new_load, kill;
  assign new_load = acc && is_load && !cond;
  assign kill     = acc && !is_load && wr_exec && (dst == trk_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_reg   <= '0;
      trk_pend  <= 1'b0;
      trk_data  <= '0;
    end else begin
      if (acc && is_load) begin
        trk_valid <= !cond;
        trk_reg   <= dst;
      end else if (kill) begin
        trk_valid <= 1'b0;
      end
      if (new_load) trk_pend <= 1'b1;
      else if (rsp_valid) trk_pend <= 1'b0;
      if (rsp_valid) trk_data <= rsp_data;
    end
  end

  assert_overwrite_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !trk_valid);
  assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !new_load) |=> !trk_pend);
  assert_cond_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_load && cond) |=> !trk_valid);
endmodule

// File: rtl/opbyp_opsel.sv
module opbyp_opsel
  import opbyp_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int RW    = 4,
  parameter int DW    = 32
) (
  input  logic             use_op,
  input  logic [RW-1:0]    src,
  input  logic [NREGS-1:0] lock,
  input  logic [DW-1:0]    rf_data,
  input  logic             lr_valid,
  input  logic [RW-1:0]    lr_reg,
  input  logic             lr_pend,
  input  logic [DW-1:0]    lr_data,
  input  logic             ld_valid,
  input  logic [RW-1:0]    ld_reg,
  input  logic             ld_pend,
  input  logic [DW-1:0]    ld_data,
  output logic [1:0]       sel,
  output logic [DW-1:0]    data,
  output logic             wait_o
);
  logic lr_hit, ld_hit;
  assign lr_hit = use_op && lr_valid && (lr_reg == src);
  assign ld_hit = use_op && ld_valid && (ld_reg == src);

  always_comb begin
    sel    = SRC_RF;
    data   = rf_data;
    wait_o = 1'b0;
    if (lr_hit) begin
      sel    = SRC_LAST;
      data   = lr_data;
      wait_o = lr_pend;
    end else if (ld_hit) begin
      sel    = SRC_LOAD;
      data   = ld_data;
      wait_o = ld_pend;
    end else if (use_op) begin
      wait_o = lock[src];
    end
  end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opbyp_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic             dec_use_a,
  input  logic [RW-1:0]    dec_src_a,
  input  logic             dec_use_b,
  input  logic [RW-1:0]    dec_src_b,
  input  logic [RW-1:0]    dec_dst,
  input  logic             dec_exec_wr,
  input  logic             dec_load,
  input  logic             dec_cond,
  input  logic             exe_res_valid,
  input  logic [DW-1:0]    exe_res_data,
  input  logic             ld_rsp_valid,
  input  logic [DW-1:0]    ld_rsp_data,
  input  logic [NREGS-1:0] reg_lock,
  input  logic [DW-1:0]    rf_data_a,
  input  logic [DW-1:0]    rf_data_b,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [DW-1:0]    opnd_a,
  output logic [DW-1:0]    opnd_b,
  output logic             stall
);
  localparam int NOPS = 2;

  logic          acc, wr_exec;
  logic          lr_valid, lr_pend, ld_valid, ld_pend;
  logic [RW-1:0] lr_reg, ld_reg;
  logic [DW-1:0] lr_data, ld_data;

  logic          use_w  [NOPS];
  logic [RW-1:0] src_w  [NOPS];
  logic [DW-1:0] rf_w   [NOPS];
  logic [1:0]    sel_w  [NOPS];
  logic [DW-1:0] data_w [NOPS];
  logic [NOPS-1:0] wait_w;

  assign use_w[0] = dec_use_a;
  assign use_w[1] = dec_use_b;
  assign src_w[0] = dec_src_a;
  assign src_w[1] = dec_src_b;
  assign rf_w[0]  = rf_data_a;
  assign rf_w[1]  = rf_data_b;

  assign wr_exec   = dec_exec_wr && !dec_load;
  assign dec_ready = ~|wait_w;
  assign acc       = dec_valid && dec_ready;
  assign stall     = dec_valid && (|wait_w);

  opbyp_last_result #(.RW(RW), .DW(DW)) u_lr (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr_exec(wr_exec), .cond(dec_cond),
    .dst(dec_dst), .wb_valid(exe_res_valid), .wb_data(exe_res_data),
    .trk_valid(lr_valid), .trk_reg(lr_reg), .trk_pend(lr_pend), .trk_data(lr_data)
  );

  opbyp_last_load #(.RW(RW), .DW(DW)) u_ld (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_load(dec_load), .wr_exec(wr_exec),
    .cond(dec_cond), .dst(dec_dst), .rsp_valid(ld_rsp_valid), .rsp_data(ld_rsp_data),
    .trk_valid(ld_valid), .trk_reg(ld_reg), .trk_pend(ld_pend), .trk_data(ld_data)
  );

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    opbyp_opsel #(.NREGS(NREGS), .RW(RW), .DW(DW)) u_sel (
      .use_op(use_w[i]), .src(src_w[i]), .lock(reg_lock), .rf_data(rf_w[i]),
      .lr_valid(lr_valid), .lr_reg(lr_reg), .lr_pend(lr_pend), .lr_data(lr_data),
      .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_pend(ld_pend), .ld_data(ld_data),
      .sel(sel_w[i]), .data(data_w[i]), .wait_o(wait_w[i])
    );
  end

  assign sel_a  = sel_w[0];
  assign sel_b  = sel_w[1];
  assign opnd_a = data_w[0];
  assign opnd_b = data_w[1];

  assert_load_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec_use_a && sel_a == SRC_LOAD) |-> !ld_pend);
  assert_last_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec_use_b && sel_b == SRC_LAST) |-> !lr_pend);
  assert_lock_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use_a && sel_a == SRC_RF && reg_lock[dec_src_a]) |-> stall);
  assert_unused_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_use_b |-> (sel_b == SRC_RF));
endmodule

// File: tb/opnd_bypass_tb.sv
module opnd_bypass_tb;
  localparam int NREGS = 16;
  localparam int DW = 32;
  localparam int RW = $clog2(NREGS);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_valid = 0, dec_use_a = 0, dec_use_b = 0, dec_exec_wr = 0, dec_load = 0, dec_cond = 0;
  logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic exe_res_valid = 0, ld_rsp_valid = 0;
  logic [DW-1:0] exe_res_data = '0, ld_rsp_data = '0, rf_data_a = '0, rf_data_b = '0;
  logic [NREGS-1:0] reg_lock = '0;
  logic dec_ready, stall;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_bypass #(.NREGS(NREGS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_use_a(dec_use_a), .dec_src_a(dec_src_a), .dec_use_b(dec_use_b), .dec_src_b(dec_src_b),
    .dec_dst(dec_dst), .dec_exec_wr(dec_exec_wr), .dec_load(dec_load), .dec_cond(dec_cond),
    .exe_res_valid(exe_res_valid), .exe_res_data(exe_res_data),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data), .reg_lock(reg_lock),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall)
  );

  // reference tracker state
  logic m_lrv = 0, m_lrp = 0, m_ldv = 0, m_ldp = 0;
  logic [RW-1:0] m_lrr = '0, m_ldr = '0;
  logic [DW-1:0] m_lrd = '0, m_ldd = '0;

  function automatic void ev(input logic u, input logic [RW-1:0] s, input logic [DW-1:0] rf,
                             output logic [1:0] sel, output logic w, output logic [DW-1:0] d);
    sel = 2'd0; w = 1'b0; d = rf;
    if (u) begin
      if (m_lrv && m_lrr == s) begin sel = 2'd1; w = m_lrp; d = m_lrd; end
      else if (m_ldv && m_ldr == s) begin sel = 2'd2; w = m_ldp; d = m_ldd; end
      else w = reg_lock[s];
    end
  endfunction

  function automatic string tag_of(input logic [1:0] sel, input logic w);
    if (sel == 2'd1) return w ? "R10" : "R2";
    if (sel == 2'd2) return w ? "R5" : "R4";
    return w ? "R8" : "R1";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // caller drives at negedge; check, advance one edge, update model
  task automatic step(input string tag);
    logic [1:0] sa, sb; logic wa, wb, rdy, acc, wr; logic [DW-1:0] da, db;
    string t;
    #1;
    ev(dec_use_a, dec_src_a, rf_data_a, sa, wa, da);
    ev(dec_use_b, dec_src_b, rf_data_b, sb, wb, db);
    rdy = !(wa || wb);
    t = (tag == "") ? tag_of(sa, wa) : tag;
    chk({t, " sel_a"}, DW'(sel_a), DW'(sa));
    chk({t, " sel_b"}, DW'(sel_b), DW'(sb));
    chk({t, " ready"}, DW'(dec_ready), DW'(rdy));
    chk({t, " stall"}, DW'(stall), DW'(dec_valid && !rdy));
    if (!wa) chk({t, " opnd_a"}, opnd_a, da);
    if (!wb) chk({t, " opnd_b"}, opnd_b, db);
    @(posedge clk);
    acc = dec_valid && rdy;
    wr = dec_exec_wr && !dec_load;
    if (acc) begin
      if (dec_load) begin m_ldv = !dec_cond; m_ldr = dec_dst; end
      else if (wr && dec_dst == m_ldr) m_ldv = 1'b0;
      m_lrv = wr && !dec_cond;
      if (wr && !dec_cond) m_lrr = dec_dst;
    end
    if (acc && wr && !dec_cond) m_lrp = 1'b1; else if (exe_res_valid) m_lrp = 1'b0;
    if (acc && dec_load && !dec_cond) m_ldp = 1'b1; else if (ld_rsp_valid) m_ldp = 1'b0;
    if (exe_res_valid) m_lrd = exe_res_data;
    if (ld_rsp_valid) m_ldd = ld_rsp_data;
    @(negedge clk);
  endtask

  task automatic idle();
    dec_valid = 0; dec_use_a = 0; dec_use_b = 0; dec_exec_wr = 0; dec_load = 0; dec_cond = 0;
    exe_res_valid = 0; ld_rsp_valid = 0; reg_lock = '0;
  endtask

  task automatic instr(input logic ua, input int sa, input logic ub, input int sb, input int d,
                       input logic ew, input logic ld, input logic cd);
    dec_valid = 1; dec_use_a = ua; dec_src_a = RW'(sa); dec_use_b = ub; dec_src_b = RW'(sb);
    dec_dst = RW'(d); dec_exec_wr = ew; dec_load = ld; dec_cond = cd;
    exe_res_valid = 0; ld_rsp_valid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    rf_data_a = 32'hA0A0_0001; rf_data_b = 32'hB0B0_0002;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    instr(1, 3, 1, 4, 0, 0, 0, 0);
    #1; chk("R1 sel_a", DW'(sel_a), 0); chk("R1 ready", DW'(dec_ready), 1);
    chk("R1 opnd_a", opnd_a, 32'hA0A0_0001);
    step("R1");
    // R2/R3: exec writer to r3, strobe, reader of r3 with lock set
    instr(0, 0, 0, 0, 3, 1, 0, 0); step("R2");
    idle(); exe_res_valid = 1; exe_res_data = 32'h0000_1234; step("R2");
    idle(); instr(1, 3, 0, 0, 9, 0, 0, 0); reg_lock[3] = 1;
    #1; chk("R2 sel_a", DW'(sel_a), 1); chk("R2 opnd_a", opnd_a, 32'h1234);
    chk("R2 stall", DW'(stall), 0);
    step("R2");
    instr(1, 3, 0, 0, 9, 0, 0, 0); reg_lock = '0; step("R3");
    instr(1, 3, 0, 0, 9, 0, 0, 0); reg_lock[3] = 1;
    #1; chk("R3 sel_a", DW'(sel_a), 0); chk("R3 stall", DW'(stall), 1);
    step("R3");
    reg_lock = '0;
    // R4/R5: load to r5; reader stalls until data
    instr(0, 0, 0, 0, 5, 0, 1, 0); step("R4");
    instr(0, 0, 1, 5, 9, 0, 0, 0);
    #1; chk("R5 stall", DW'(stall), 1); chk("R5 sel_b", DW'(sel_b), 2);
    step("R5");
    ld_rsp_valid = 1; ld_rsp_data = 32'hBEEF; step("R5");
    ld_rsp_valid = 0;
    #1; chk("R5 ready", DW'(dec_ready), 1); chk("R4 opnd_b", opnd_b, 32'hBEEF);
    step("R4");
    instr(1, 1, 0, 0, 2, 0, 0, 0); step("R4");
    instr(1, 5, 1, 5, 9, 0, 0, 0);
    #1; chk("R4 later sel_a", DW'(sel_a), 2);
    step("R4");
    // R9/R7: exec writer to r5, then readers of r5
    instr(0, 0, 0, 0, 5, 1, 0, 0); step("R7");
    idle(); exe_res_valid = 1; exe_res_data = 32'h77; step("R9");
    instr(1, 5, 0, 0, 9, 0, 0, 0);
    #1; chk("R9 sel_a", DW'(sel_a), 1); chk("R9 opnd_a", opnd_a, 32'h77);
    step("R9");
    instr(1, 5, 0, 0, 9, 0, 0, 0);
    #1; chk("R7 sel_a", DW'(sel_a), 0);
    step("R7");
    // R6: conditional producers
    instr(0, 0, 0, 0, 6, 1, 0, 1); step("R6");
    idle(); exe_res_valid = 1; exe_res_data = 32'h66; step("R6");
    instr(1, 6, 0, 0, 9, 0, 0, 0); reg_lock[6] = 1;
    #1; chk("R6 sel_a", DW'(sel_a), 0); chk("R6 stall", DW'(stall), 1);
    step("R6");
    reg_lock = '0; step("R6");
    instr(0, 0, 0, 0, 8, 0, 1, 1); step("R6");
    instr(1, 8, 0, 0, 9, 0, 0, 0);
    #1; chk("R6 cond load sel_a", DW'(sel_a), 0);
    step("R6");
    // R10: last result pending
    instr(0, 0, 0, 0, 7, 1, 0, 0); step("R10");
    instr(0, 0, 1, 7, 9, 0, 0, 0);
    #1; chk("R10 stall", DW'(stall), 1);
    step("R10");
    exe_res_valid = 1; exe_res_data = 32'h7070; step("R10");
    exe_res_valid = 0;
    #1; chk("R10 ready", DW'(dec_ready), 1); chk("R10 opnd_b", opnd_b, 32'h7070);
    step("R10");
    // R8: unused operand ignores lock
    instr(1, 1, 0, 2, 9, 0, 0, 0); reg_lock = 16'h0004;
    #1; chk("R8 unused", DW'(stall), 0); chk("R8 sel_b", DW'(sel_b), 0);
    step("R8");
    // random phase
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      dec_valid = ($urandom % 4) != 0;
      dec_use_a = $urandom % 2; dec_use_b = $urandom % 2;
      dec_src_a = RW'($urandom % 4); dec_src_b = RW'($urandom % 4);
      dec_dst = RW'($urandom % 4);
      dec_load = ($urandom % 4) == 0; dec_exec_wr = $urandom % 2;
      dec_cond = ($urandom % 6) == 0;
      exe_res_valid = ($urandom % 3) == 0; exe_res_data = $urandom;
      ld_rsp_valid = ($urandom % 3) == 0; ld_rsp_data = $urandom;
      reg_lock = NREGS'($urandom) & NREGS'($urandom);
      rf_data_a = $urandom; rf_data_b = $urandom;
      step("");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule